// File: doc/BRIEF.md
# Time-of-Year Seconds Counter

This block keeps a running count of seconds off a slow crystal clock of nominally 32.768 kHz. That clock first passes through a prescaler whose division ratio software programs as a trim value. The ratio is trim plus one, so a trim of 32767 yields one tick per second. Each tick advances a 32-bit seconds register, which wraps to zero after the all-ones value. The slow domain keeps counting whatever the system clock domain is doing.

Software reaches the block through a small register port in the system clock domain. Each access is a one-cycle strobe that selects one of three words: the seconds value, the trim value, or a control/status word. A write of a new seconds value or trim value is posted into the slow domain. Each posted write has its own busy flag, and software polls that flag before it issues the next write of the same kind. A seconds write lands on the next prescaler rollover, so it can take up to a full tick to finish. The status word also reports whether the slow clock is toggling. It does this by counting slow-clock edges inside a fixed window of system cycles.

The system clock is assumed to run at least several times faster than the slow clock.

Top module: `toy_seconds_counter`

## Requirements
- R1: After reset the seconds value reads 0, the trim value reads 0, and the control/status word reads 0, meaning enable is 0, the oscillator flag is 0 and both busy flags are 0.
- R2: While enabled, the seconds value advances by exactly one every trim+1 slow-clock cycles.
- R3: The seconds value is 32 bits wide and steps from 0xFFFFFFFF to 0. Apart from a posted load, it only ever holds its value or increases by one.
- R4: A seconds write sets the seconds-busy flag (status bit 2) in the cycle after the write. The flag clears once the new value has been loaded in the slow domain. While counting is enabled the load happens on the next prescaler rollover. While counting is disabled it happens at once. After the flag clears, a read returns the loaded value.
- R5: A seconds write issued while the seconds-busy flag is set is ignored.
- R6: A trim write sets the trim-busy flag (status bit 3) until the slow domain has taken the value. A trim write issued while that flag is set is ignored. The trim word reads back the accepted value.
- R7: Control/status bit 0 is the enable bit. It is set or cleared by writing bit 0 of the control word. While it is 0, the seconds value does not change.
- R8: Status bit 1, the oscillator flag, is evaluated at the end of each window of WIN_CYC system cycles. It is set when at least MIN_EDGES rising slow-clock edges were seen in that window and cleared otherwise. It changes at no other time.
- R9: The select encoding is 0 for seconds, 1 for trim and 2 for control/status. The read data is registered: it is updated in the cycle after a read access and holds its value otherwise.
- R10: A seconds read returns a whole value that the slow domain actually held. It is captured only after the slow domain signals a completed update, so no read shows a torn multi-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain (also synchronized into the slow domain) |
| lf_clk | input | 1 | Slow counting clock, nominally 32.768 kHz |
| acc_en | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | 1 for a write access, 0 for a read access |
| acc_sel | input | 2 | Word select: 0 seconds, 1 trim, 2 control/status |
| acc_wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
Some properties are checked on every cycle by the embedded assertions. Read data holds still between reads. A busy flag rises only after a matching write. A write that arrives while its flag is busy leaves the held value untouched. The seconds register only holds or steps by one unless a load is pending. The prescaler returns to zero after each tick. The oscillator flag moves only at a window boundary. Other behaviour can only be shown by the bench's scenarios. These are the exact tick rate for several trim values, where the posted writes actually land, the wrap from all-ones to zero, the frozen count while disabled, and the oscillator flag dropping after the slow clock stops.

// File: rtl/toy_pkg.sv
package toy_pkg;

    localparam int DEF_SEC_W  = 32;
    localparam int DEF_TRIM_W = 16;
    localparam int STAT_W     = 4;

    typedef enum logic [1:0] {
        SEL_SEC  = 2'd0,
        SEL_TRIM = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // packed order gives bit 3 .. bit 0
    typedef struct packed {
        logic trim_busy;
        logic sec_busy;
        logic osc_ok;
        logic enable;
    } stat_t;

    function automatic logic [STAT_W-1:0] pack_stat(input stat_t s);
        return s;
    endfunction

endpackage

// File: rtl/toy_sync.sv
module toy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/toy_osc_detect.sv
module toy_osc_detect #(
    parameter int WIN_CYC   = 16384,
    parameter int MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lf_clk,
    output logic osc_ok
);
    localparam int WW = $clog2(WIN_CYC);
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);
    localparam logic [EW-1:0] EDGE_MAX = EW'(MIN_EDGES);

    logic          lf_s;
    logic          lf_prev;
    logic          rise;
    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] edge_nxt;
    logic          win_end;

    toy_sync #(.STAGES(2)) u_lf_sync (.clk(clk), .d(lf_clk), .q(lf_s));

    assign rise     = lf_s & ~lf_prev;
    assign win_end  = (win_cnt == WIN_LAST);
    assign edge_nxt = (rise && edge_cnt != EDGE_MAX) ? edge_cnt + EW'(1) : edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lf_prev  <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
            osc_ok   <= 1'b0;
        end else begin
            lf_prev <= lf_s;
            if (win_end) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                osc_ok   <= (edge_nxt == EDGE_MAX);
            end else begin
                win_cnt  <= win_cnt + WW'(1);
                edge_cnt <= edge_nxt;
            end
        end
    end

    // R8
    osc_window_only_chk: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(osc_ok));
endmodule

// File: rtl/toy_slow_core.sv
module toy_slow_core #(
    parameter int SEC_W  = 32,
    parameter int TRIM_W = 16
) (
    input  logic              lf_clk,
    input  logic              rst_in,
    input  logic              en_in,
    input  logic              sec_req_t,
    input  logic [SEC_W-1:0]  sec_data,
    input  logic              trim_req_t,
    input  logic [TRIM_W-1:0] trim_data,
    output logic [SEC_W-1:0]  sec,
    output logic              sec_ack_t,
    output logic              trim_ack_t,
    output logic              pub_t
);
    logic              rst_lf;
    logic              en_s;
    logic              sec_req_s;
    logic              trim_req_s;
    logic [TRIM_W-1:0] trim;
    logic [TRIM_W-1:0] pre;
    logic              tick;
    logic              ld_pend;

    toy_sync #(.STAGES(2)) u_rst_sync  (.clk(lf_clk), .d(rst_in),     .q(rst_lf));
    toy_sync #(.STAGES(2)) u_en_sync   (.clk(lf_clk), .d(en_in),      .q(en_s));
    toy_sync #(.STAGES(2)) u_sreq_sync (.clk(lf_clk), .d(sec_req_t),  .q(sec_req_s));
    toy_sync #(.STAGES(2)) u_treq_sync (.clk(lf_clk), .d(trim_req_t), .q(trim_req_s));

    assign tick    = en_s && (pre >= trim);
    assign ld_pend = (sec_req_s != sec_ack_t);

    always_ff @(posedge lf_clk) begin
        if (rst_lf) begin
            trim       <= '0;
            pre        <= '0;
            sec        <= '0;
            sec_ack_t  <= 1'b0;
            trim_ack_t <= 1'b0;
            pub_t      <= 1'b0;
        end else begin
            if (trim_req_s != trim_ack_t) begin
                trim       <= trim_data;
                trim_ack_t <= trim_req_s;
            end
            if (en_s) begin
                pre <= tick ? '0 : pre + TRIM_W'(1);
            end
            if (ld_pend && (tick || !en_s)) begin
                sec       <= sec_data;
                sec_ack_t <= sec_req_s;
                pub_t     <= ~pub_t;
            end else if (tick) begin
                sec   <= sec + SEC_W'(1);
                pub_t <= ~pub_t;
            end
        end
    end

    // R2
    pre_restart_chk: assert property (@(posedge lf_clk) disable iff (rst_lf)
        tick |=> (pre == '0));

    // R3
    sec_step_chk: assert property (@(posedge lf_clk) disable iff (rst_lf)
        !ld_pend |=> (sec == $past(sec) || sec == $past(sec) + SEC_W'(1)));
endmodule

// File: rtl/toy_seconds_counter.sv
module toy_seconds_counter
    import toy_pkg::*;
#(
    parameter int SEC_W     = DEF_SEC_W,
    parameter int TRIM_W    = DEF_TRIM_W,
    parameter int WIN_CYC   = 16384,
    parameter int MIN_EDGES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lf_clk,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [1:0]       acc_sel,
    input  logic [SEC_W-1:0] acc_wdata,
    output logic [SEC_W-1:0] rdata
);
    localparam int TRIM_PAD = SEC_W - TRIM_W;
    localparam int STAT_PAD = SEC_W - STAT_W;

    reg_sel_e          sel;
    logic              wr_acc;
    logic              rd_acc;
    logic              enable;
    logic [SEC_W-1:0]  sec_hold;
    logic [TRIM_W-1:0] trim_hold;
    logic              sec_req_t;
    logic              trim_req_t;
    logic [SEC_W-1:0]  sec_lf;
    logic              sec_ack_lf;
    logic              trim_ack_lf;
    logic              pub_lf;
    logic              sec_ack_s;
    logic              trim_ack_s;
    logic              pub_s;
    logic              sec_ack_q;
    logic              pub_prev;
    logic [SEC_W-1:0]  sec_view;
    logic              osc_ok;
    logic              sec_busy;
    logic              trim_busy;
    stat_t             stat;

    assign sel       = reg_sel_e'(acc_sel);
    assign wr_acc    = acc_en && acc_wr;
    assign rd_acc    = acc_en && !acc_wr;
    assign sec_busy  = sec_req_t ^ sec_ack_q;
    assign trim_busy = trim_req_t ^ trim_ack_s;
    assign stat      = '{trim_busy: trim_busy, sec_busy: sec_busy,
                         osc_ok: osc_ok, enable: enable};

    toy_slow_core #(.SEC_W(SEC_W), .TRIM_W(TRIM_W)) u_core (
        .lf_clk     (lf_clk),
        .rst_in     (rst),
        .en_in      (enable),
        .sec_req_t  (sec_req_t),
        .sec_data   (sec_hold),
        .trim_req_t (trim_req_t),
        .trim_data  (trim_hold),
        .sec        (sec_lf),
        .sec_ack_t  (sec_ack_lf),
        .trim_ack_t (trim_ack_lf),
        .pub_t      (pub_lf)
    );

    toy_sync #(.STAGES(2)) u_sack_sync (.clk(clk), .d(sec_ack_lf),  .q(sec_ack_s));
    toy_sync #(.STAGES(2)) u_tack_sync (.clk(clk), .d(trim_ack_lf), .q(trim_ack_s));
    toy_sync #(.STAGES(2)) u_pub_sync  (.clk(clk), .d(pub_lf),      .q(pub_s));

    toy_osc_detect #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_osc (
        .clk    (clk),
        .rst    (rst),
        .lf_clk (lf_clk),
        .osc_ok (osc_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable     <= 1'b0;
            sec_hold   <= '0;
            trim_hold  <= '0;
            sec_req_t  <= 1'b0;
            trim_req_t <= 1'b0;
            sec_ack_q  <= 1'b0;
            pub_prev   <= 1'b0;
            sec_view   <= '0;
            rdata      <= '0;
        end else begin
            sec_ack_q <= sec_ack_s;
            pub_prev  <= pub_s;
            if (pub_s != pub_prev) begin
                sec_view <= sec_lf;
            end
            if (wr_acc) begin
                case (sel)
                    SEL_SEC: if (!sec_busy) begin
                        sec_hold  <= acc_wdata;
                        sec_req_t <= ~sec_req_t;
                    end
                    SEL_TRIM: if (!trim_busy) begin
                        trim_hold  <= acc_wdata[TRIM_W-1:0];
                        trim_req_t <= ~trim_req_t;
                    end
                    SEL_CTRL: enable <= acc_wdata[0];
                    default: ;
                endcase
            end
            if (rd_acc) begin
                case (sel)
                    SEL_SEC:  rdata <= sec_view;
                    SEL_TRIM: rdata <= {{TRIM_PAD{1'b0}}, trim_hold};
                    SEL_CTRL: rdata <= {{STAT_PAD{1'b0}}, pack_stat(stat)};
                    default:  rdata <= '0;
                endcase
            end
        end
    end

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> $stable(rdata));

    // R4
    sec_busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_busy) |-> $past(wr_acc && sel == SEL_SEC));

    // R6
    trim_busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trim_busy) |-> $past(wr_acc && sel == SEL_TRIM));

    // R5
    sec_busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && sel == SEL_SEC && sec_busy) |=> $stable(sec_hold));

    // R6
    trim_busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && sel == SEL_TRIM && trim_busy) |=> $stable(trim_hold));
endmodule

// File: tb/toy_seconds_counter_test.sv
module toy_seconds_counter_test;

    localparam int WIN = 512;
    localparam int MINE = 4;

    typedef struct packed {
        logic [15:0] trim;
        logic [31:0] ticks;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{trim: 16'd0, ticks: 32'd8},
        '{trim: 16'd1, ticks: 32'd5},
        '{trim: 16'd3, ticks: 32'd4},
        '{trim: 16'd6, ticks: 32'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lf_clk = 1'b0;
    logic        lf_run = 1'b1;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_sel = 2'd0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    toy_seconds_counter #(.WIN_CYC(WIN), .MIN_EDGES(MINE)) uut (
        .clk       (clk),
        .rst       (rst),
        .lf_clk    (lf_clk),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .rdata     (rdata)
    );

    always #5 clk = ~clk;

    always begin
        #200;
        if (lf_run) lf_clk = ~lf_clk;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_sel = s;
        @(negedge clk);
        acc_en = 1'b0;
        v = rdata;
    endtask

    task automatic do_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_sel = s; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic wait_idle(input int bitpos, input string tag);
        logic [31:0] v;
        bit ok;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            do_read(2'd2, v);
            if (!v[bitpos]) begin
                ok = 1'b1;
                break;
            end
        end
        if (!ok) check(tag, 32'd1, 32'd0);
    endtask

    task automatic lf_wait(input int n);
        for (int i = 0; i < n; i++) @(posedge lf_clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v1, v2;
        repeat (300) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        do_read(2'd0, v); check("R1 seconds", v, 32'd0);
        do_read(2'd1, v); check("R1 trim", v, 32'd0);
        do_read(2'd2, v); check("R1 status", v, 32'd0);

        // R8 oscillator seen
        repeat (2 * WIN + 20) @(negedge clk);
        do_read(2'd2, v); check("R8 osc set", v, 32'h2);

        // R6 trim busy, ignored second write, readback
        do_write(2'd1, 32'd5);
        do_read(2'd2, v); check("R6 trim busy", v & 32'h8, 32'h8);
        do_write(2'd1, 32'd9);
        wait_idle(3, "R6 trim idle");
        do_read(2'd1, v); check("R6 trim readback", v, 32'd5);

        // R7 disabled count holds
        do_read(2'd0, v1);
        lf_wait(40);
        do_read(2'd0, v2); check("R7 hold disabled", v2, v1);

        do_write(2'd2, 32'd1);
        do_read(2'd2, v); check("R7 enable bit", v & 32'h1, 32'h1);

        // R2 R10 rate table
        for (int k = 0; k < 4; k++) begin
            do_write(2'd1, {16'd0, VEC[k].trim});
            wait_idle(3, "R2 trim idle");
            lf_wait(64);
            do_read(2'd0, v1);
            lf_wait(int'(VEC[k].ticks) * (int'(VEC[k].trim) + 1));
            do_read(2'd0, v2);
            check("R2 R10 tick rate", v2 - v1, VEC[k].ticks);
        end

        // R4 R5 posted seconds write, trim now 6
        do_write(2'd0, 32'd1000);
        do_read(2'd2, v); check("R4 sec busy", v & 32'h4, 32'h4);
        do_write(2'd0, 32'd2000);
        wait_idle(2, "R4 sec idle");
        do_read(2'd0, v); check("R4 R5 loaded value", v, 32'd1000);

        // R3 wrap
        do_write(2'd0, 32'hFFFF_FFFF);
        wait_idle(2, "R3 sec idle");
        do_read(2'd0, v); check("R3 all ones", v, 32'hFFFF_FFFF);
        lf_wait(10);
        do_read(2'd0, v); check("R3 wrap to zero", v, 32'd0);

        // R4 R7 immediate load while disabled, then hold
        do_write(2'd2, 32'd0);
        lf_wait(4);
        do_write(2'd0, 32'd77);
        wait_idle(2, "R4 idle disabled");
        do_read(2'd0, v); check("R4 load disabled", v, 32'd77);
        lf_wait(30);
        do_read(2'd0, v); check("R7 hold after load", v, 32'd77);

        // R9 select 3 reads zero
        do_read(2'd3, v); check("R9 unused select", v, 32'd0);

        // R8 oscillator lost
        lf_run = 1'b0;
        repeat (3 * WIN) @(negedge clk);
        do_read(2'd2, v); check("R8 osc cleared", v & 32'h2, 32'h0);

        finish_run();
    end
endmodule